// File: doc/BRIEF.md
# Loadable Down-Counting Event Timer

A single-channel timer on a plain 32-bit register port: a word address, a write strobe, write data, and read data that follows the address within the same cycle. Software writes a 64-bit reload value as two words, chooses one-shot or periodic operation and a 32-bit or 64-bit count width, and sets the run bit. The counter then steps down once per clock. When it reaches zero it flags an expiry. In periodic mode it refills itself from the reload value and keeps running. In one-shot mode it parks at zero and drops its run bit.

Each expiry sets a sticky raw flag. The raw flag ANDed with an enable bit drives a level interrupt. Software drops the flag by writing a one to a clear bit. The running count can be read at two address pairs. Both return the same value, so a reader can sample high, low, high and retry on a mismatch. Loaded with all ones in 64-bit periodic mode, the block serves as a free-running 64-bit time base whose bitwise inverse increases.

Top module: `ctmr_top`

## Requirements
- R1: After reset every register reads 0 and irq_o is low.
- R2: Word offsets: 0x00 reload low, 0x04 reload high (both read/write); 0x10 control with bit 0 periodic (1) / one-shot (0), bit 1 run, bit 16 width 64 (1) / 32 (0), other bits read 0. An address whose two low bits are not zero reads 0 and ignores writes.
- R3: While run is set and no expiry occurs, the count falls by exactly one per clock. With run clear the count holds.
- R4: A control write that takes run from 0 to 1 loads the count from the reload value on that edge. Reload writes made while running do not alter the count until the next refill or start.
- R5: In periodic mode, a count of zero while running causes the next edge to refill from the reload value and set the raw flag. With reload L, expiries repeat every L+1 clocks.
- R6: In one-shot mode, expiry sets the raw flag, clears the run bit (control bit 1 reads 0), and the count stays at 0.
- R7: In 32-bit width only the low reload word is used. The count high word reads 0, and expiry happens when the low word is zero.
- R8: In 64-bit width the count borrows from the high word into the low word. With both reload words all ones and periodic mode, the count runs freely.
- R9: At offset 0x14: bit 0 interrupt enable (read/write), bit 1 raw flag (read only), bit 2 raw AND enable (read only), bit 3 clears the raw flag when written 1 and reads 0. irq_o equals bit 2.
- R10: If an expiry and a clear write fall on the same edge, the raw flag ends up set.
- R11: Offsets 0x18 and 0x1C return the same low and high count words as 0x08 and 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted count appears at the value or shadow words in the cycle after the bad edge. It also shifts the next expiry, and irq_o then rises one or more clocks away from its expected cycle. A wrong run or mode bit shows at once in the control readback, and a raw flag held or dropped wrongly shows in the interrupt word and on irq_o in the next cycle. The bench cycles the read address through all eight words and compares the read data and irq_o against a reference model on every clock, so most faults are reported within eight cycles.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int DW     = 32;
  localparam int AW     = 5;
  localparam int CW     = 2 * DW;

  localparam logic [2:0] W_LOAD_LO = 3'd0;
  localparam logic [2:0] W_LOAD_HI = 3'd1;
  localparam logic [2:0] W_VAL_LO  = 3'd2;
  localparam logic [2:0] W_VAL_HI  = 3'd3;
  localparam logic [2:0] W_CTRL    = 3'd4;
  localparam logic [2:0] W_INTR    = 3'd5;
  localparam logic [2:0] W_SHD_LO  = 3'd6;
  localparam logic [2:0] W_SHD_HI  = 3'd7;

  localparam int B_PERIODIC = 0;
  localparam int B_RUN      = 1;
  localparam int B_WIDE     = 16;

  localparam int B_IEN  = 0;
  localparam int B_RAW  = 1;
  localparam int B_MSK  = 2;
  localparam int B_CLR  = 3;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          expire_i,
  input  logic          raw_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] load_o,
  output logic          periodic_o,
  output logic          run_o,
  output logic          wide_o,
  output logic          ien_o,
  output logic          start_o,
  output logic          start_wide_o,
  output logic          clr_o,
  output logic [DW-1:0] rd_data_o
);
  logic          aligned;
  logic [2:0]    widx;
  logic          wr_ok;
  logic [CW-1:0] load_q;
  logic          per_q, run_q, wide_q, ien_q;
  logic          wr_ctrl;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign widx    = addr_i[4:2];
  assign wr_ok   = wr_en_i && aligned;
  assign wr_ctrl = wr_ok && (widx == W_CTRL);

  assign start_o      = wr_ctrl && wr_data_i[B_RUN] && !run_q;
  assign start_wide_o = wr_data_i[B_WIDE];
  assign clr_o        = wr_ok && (widx == W_INTR) && wr_data_i[B_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      per_q  <= 1'b0;
      run_q  <= 1'b0;
      wide_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ok && widx == W_LOAD_LO) load_q[DW-1:0]  <= wr_data_i;
      if (wr_ok && widx == W_LOAD_HI) load_q[CW-1:DW] <= wr_data_i;
      if (wr_ok && widx == W_INTR)    ien_q <= wr_data_i[B_IEN];
      if (wr_ctrl) begin
        per_q  <= wr_data_i[B_PERIODIC];
        run_q  <= wr_data_i[B_RUN];
        wide_q <= wr_data_i[B_WIDE];
      end else if (expire_i && !per_q) begin
        run_q <= 1'b0;   // one-shot parks
      end
    end
  end

  assign load_o     = load_q;
  assign periodic_o = per_q;
  assign run_o      = run_q;
  assign wide_o     = wide_q;
  assign ien_o      = ien_q;

  logic [DW-1:0] cnt_hi_vis;
  assign cnt_hi_vis = wide_q ? cnt_i[CW-1:DW] : '0;

  always_comb begin
    rd_data_o = '0;
    if (aligned) begin
      unique case (widx)
        W_LOAD_LO: rd_data_o = load_q[DW-1:0];
        W_LOAD_HI: rd_data_o = load_q[CW-1:DW];
        W_VAL_LO, W_SHD_LO: rd_data_o = cnt_i[DW-1:0];
        W_VAL_HI, W_SHD_HI: rd_data_o = cnt_hi_vis;
        W_CTRL: begin
          rd_data_o[B_PERIODIC] = per_q;
          rd_data_o[B_RUN]      = run_q;
          rd_data_o[B_WIDE]     = wide_q;
        end
        W_INTR: begin
          rd_data_o[B_IEN] = ien_q;
          rd_data_o[B_RAW] = raw_i;
          rd_data_o[B_MSK] = raw_i & ien_q;
        end
        default: rd_data_o = '0;
      endcase
    end
  end

  p_oneshot_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !per_q && !wr_ctrl) |=> !run_q);
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] load_i,
  input  logic          run_i,
  input  logic          periodic_i,
  input  logic          wide_i,
  input  logic          start_i,
  input  logic          start_wide_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] fill_now, fill_start;

  assign fill_now   = wide_i       ? load_i : {{DW{1'b0}}, load_i[DW-1:0]};
  assign fill_start = start_wide_i ? load_i : {{DW{1'b0}}, load_i[DW-1:0]};

  assign expire_o = run_i && (wide_i ? (cnt_q == '0) : (cnt_q[DW-1:0] == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= fill_start;
    else if (expire_o) begin
      if (periodic_i)     cnt_q <= fill_now;
    end
    else if (run_i)       cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !expire_o && !start_i) |=> (cnt_q == $past(cnt_q) - 64'd1));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(cnt_q));
  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q[DW-1:0] == $past(load_i[DW-1:0])));
  p_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !periodic_i && !start_i) |=> (cnt_q[DW-1:0] == '0));
endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic raw_o,
  output logic irq_o
);
  logic raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       raw_q <= 1'b0;
    else if (expire_i) raw_q <= 1'b1;   // expiry beats clear
    else if (clr_i)    raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & ien_i;

  p_exp_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> raw_q);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !raw_q);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && !clr_i) |=> raw_q);
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  logic [CW-1:0] load, cnt;
  logic          periodic, run, wide, ien, start, start_wide, clr, expire, raw;

  ctmr_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i,
    .expire_i(expire), .raw_i(raw), .cnt_i(cnt),
    .load_o(load), .periodic_o(periodic), .run_o(run), .wide_o(wide),
    .ien_o(ien), .start_o(start), .start_wide_o(start_wide), .clr_o(clr),
    .rd_data_o
  );

  ctmr_core u_core (
    .clk_i, .rst_ni, .load_i(load), .run_i(run), .periodic_i(periodic),
    .wide_i(wide), .start_i(start), .start_wide_i(start_wide),
    .expire_o(expire), .cnt_o(cnt)
  );

  ctmr_irq u_irq (
    .clk_i, .rst_ni, .expire_i(expire), .clr_i(clr), .ien_i(ien),
    .raw_o(raw), .irq_o
  );
endmodule

// File: tb/sim_ctmr_top.sv
`timescale 1ns/1ps
module sim_ctmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  ctmr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [63:0] m_load, m_cnt;
  bit        m_per, m_run, m_wide, m_ien, m_raw;
  int        n_cmp = 0, n_bad = 0;
  string     cur_req = "R1";
  bit        done = 0;

  always @(posedge clk or negedge rst_n) begin
    bit        exp_now, st;
    bit [63:0] fill;
    if (!rst_n) begin
      m_load = 0; m_cnt = 0; m_per = 0; m_run = 0; m_wide = 0; m_ien = 0; m_raw = 0;
    end else begin
      exp_now = m_run && (m_wide ? (m_cnt == 0) : (m_cnt[31:0] == 0));
      st = we && addr == 5'h10 && wdata[1] && !m_run;
      fill = m_wide ? m_load : {32'h0, m_load[31:0]};
      if (st) m_cnt = wdata[16] ? m_load : {32'h0, m_load[31:0]};
      else if (exp_now) begin if (m_per) m_cnt = fill; end
      else if (m_run) m_cnt = m_cnt - 1;
      if (exp_now) m_raw = 1;
      else if (we && addr == 5'h14 && wdata[3]) m_raw = 0;
      if (we && addr == 5'h10) begin
        m_per = wdata[0]; m_run = wdata[1]; m_wide = wdata[16];
      end else if (exp_now && !m_per) m_run = 0;
      if (we && addr == 5'h00) m_load[31:0]  = wdata;
      if (we && addr == 5'h04) m_load[63:32] = wdata;
      if (we && addr == 5'h14) m_ien = wdata[0];
    end
  end

  function automatic bit [31:0] model_rd(input bit [4:0] a);
    case (a)
      5'h00: return m_load[31:0];
      5'h04: return m_load[63:32];
      5'h08, 5'h18: return m_cnt[31:0];
      5'h0C, 5'h1C: return m_wide ? m_cnt[63:32] : 32'h0;
      5'h10: return {15'h0, m_wide, 14'h0, m_run, m_per};
      5'h14: return {29'h0, m_raw & m_ien, m_raw, m_ien};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input bit [31:0] act, input bit [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s t=%0t actual=%h expected=%h", req, what, $time, act, expv);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, "rd_data", rdata, model_rd(addr));
    check(cur_req, "irq_o", {31'h0, irq}, {31'h0, m_raw & m_ien});
  end

  int rot = 0;
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      we = 0; addr = 5'(rot * 4); rot = (rot + 1) % 8;
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input bit [4:0] a, input bit [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    cur_req = "R1"; idle(9);

    cur_req = "R2";
    wr(5'h00, 32'h1234_5678); wr(5'h04, 32'hA5A5_A5A5);
    wr(5'h10, 32'hFFFF_FFFC); idle(8);
    wr(5'h02, 32'hFFFF_FFFF); idle(8);   // misaligned write ignored
    wr(5'h10, 32'h0); idle(2);

    cur_req = "R9"; wr(5'h14, 32'h1); idle(2);

    cur_req = "R4";
    wr(5'h00, 32'd20); wr(5'h04, 32'h0);
    wr(5'h10, 32'h2); idle(4);
    wr(5'h00, 32'd99); idle(4);
    cur_req = "R3"; idle(10);
    cur_req = "R6"; idle(12);
    cur_req = "R9"; wr(5'h14, 32'h9); idle(4);
    wr(5'h14, 32'h0); idle(3);
    cur_req = "R3"; idle(8);   // run cleared: count holds

    cur_req = "R5";
    wr(5'h00, 32'd5); wr(5'h10, 32'h3); idle(30);
    wr(5'h10, 32'h0); wr(5'h14, 32'h9); wr(5'h14, 32'h1);

    cur_req = "R10";
    wr(5'h10, 32'h3); idle(5);
    wr(5'h14, 32'h9);   // lands on the expiry edge
    idle(3);
    wr(5'h10, 32'h0); wr(5'h14, 32'h9); idle(2);

    cur_req = "R7";
    wr(5'h00, 32'd3); wr(5'h04, 32'd7);
    wr(5'h10, 32'h3); idle(16);
    wr(5'h10, 32'h0); wr(5'h14, 32'h9); idle(2);

    cur_req = "R8";
    wr(5'h00, 32'd2); wr(5'h04, 32'd1);
    wr(5'h10, 32'h0001_0003); idle(24);
    wr(5'h10, 32'h0);
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0001_0003);
    cur_req = "R11"; idle(40);

    finish_run();
  end
endmodule